// File: doc/BRIEF.md
# Multi-Master I2C SCL Clock Synchronizer

This block produces the SCL clock of one I2C master so that it keeps in step with every other master on the same open-drain clock wire. The wire is a wired-AND: any device pulling low holds it low. The block counts a programmable low period and a programmable high period, both in system clock cycles. It watches the bus level through a synchronizer. A falling bus edge seen during its high phase makes it abandon that phase and start driving low. After its own low period it releases the wire, but it starts counting high only once it sees the wire actually rise.

Because every master stays low for its own low period and restarts its low phase on the first fall, the shared clock takes the longest low period and the shortest high period among the masters. A wait-state output shows each cycle in which the block has released the wire but still sees it low.

Top module: `scl_clk_sync`

## Requirements
- R1: While `en` is low, `scl_drive_low` and `wait_state` are 0 from the second cycle after `en` was sampled low, and the counters are cleared.
- R2: After reset, or after being disabled, the cycle after `en` is first sampled high the block drives low (`scl_drive_low` = 1). Its first phase is therefore the low phase.
- R3: The low phase lasts exactly `low_period` cycles of `scl_drive_low` = 1, after which the wire is released.
- R4: After release, high counting begins three cycles after the bus rises (two synchronizer stages plus the state register). The phase then lasts `high_period` cycles, so a lone master gives a bus high time of `high_period` + 3 cycles.
- R5: While another device holds the wire low after release, no high time is counted and `scl_drive_low` stays 0. The high time after the wire is freed is the full `high_period` + 3, measured from the bus rise.
- R6: A bus falling edge during the high phase forces `scl_drive_low` to 1 three cycles after the bus fall. The block then runs a full `low_period`.
- R7: `wait_state` is 1 in every cycle in which the block is enabled, has released the wire and sees the synchronized bus low, and is never 1 while driving low. A lone master shows exactly 2 such cycles per clock period.
- R8: A period value of 0 is treated as 1, so with both periods at 0 a lone master gives a bus low of 1 cycle and a bus high of 4 cycles.
- R9: With two masters, the bus high time is the smaller `high_period` + 3. The master with the smaller high period leads each fall, and the bus low time is the larger of its `low_period` and the other master's `low_period` + 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables clock generation; low releases the wire and idles |
| low_period | input | 16 | Low phase length in clock cycles (0 acts as 1) |
| high_period | input | 16 | High phase length in clock cycles (0 acts as 1) |
| scl_in | input | 1 | Asynchronous sampled level of the shared SCL wire |
| scl_drive_low | output | 1 | 1 = pull the SCL wire low, 0 = release it |
| wait_state | output | 1 | Released but the synchronized bus is still low |

## Verification
The hardest situations to reach from the ports are a bus fall that arrives in the middle of the high phase and a bus held low long after the block's own low period has ended. Both need a second driver on the wire. The bench builds a wired-AND bus from the design under test, a second copy of the block with different periods, and a bench-controlled pull-down. It pulses the pull-down for one cycle during a long high phase, and it holds the pull-down for forty cycles right after the block releases the wire. The two-copy setups then check that the shared clock takes the combined period values, using two period mixes that swap which low period dominates.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

    localparam int CNT_W_DEF       = 16;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    typedef struct packed {
        logic level;
        logic rose;
        logic fell;
    } bus_view_t;

    function automatic logic phase_released(input phase_e ph);
        return (ph == PH_WAIT) || (ph == PH_HIGH);
    endfunction

endpackage

// File: rtl/scl_bus_sync.sv
module scl_bus_sync
    import scl_sync_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_raw,
    output bus_view_t view
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= bus_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], bus_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain_q[STAGES-1];
    end

    always_comb begin
        view.level = chain_q[STAGES-1];
        view.rose  = chain_q[STAGES-1] & ~last_q;
        view.fell  = ~chain_q[STAGES-1] & last_q;
    end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_eff;

    assign lim_eff = (limit == '0) ? ONE : limit;
    assign done    = run && (cnt_q >= (lim_eff - ONE));

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (run)     cnt_q <= cnt_q + ONE;
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_sync_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tmr_done,
    input  logic   bus_rose,
    input  logic   bus_fell,
    output phase_e st_q,
    output logic   tmr_clear,
    output logic   tmr_run,
    output logic   sel_high
);
    phase_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_IDLE: st_d = PH_LOW;
            PH_LOW:  if (tmr_done) st_d = PH_WAIT;
            PH_WAIT: if (bus_rose) st_d = PH_HIGH;
            PH_HIGH: if (bus_fell || tmr_done) st_d = PH_LOW;
            default: st_d = PH_IDLE;
        endcase
        if (!en) st_d = PH_IDLE;
    end

    always_comb begin
        tmr_run   = (st_q == PH_LOW) || (st_q == PH_HIGH);
        tmr_clear = (st_d != st_q) || !en;
        sel_high  = (st_q == PH_HIGH);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PH_IDLE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/scl_clk_sync.sv
module scl_clk_sync
    import scl_sync_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] low_period,
    input  logic [CNT_W-1:0] high_period,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             wait_state
);
    bus_view_t        bus_v;
    phase_e           st_q;
    logic             tmr_clear;
    logic             tmr_run;
    logic             tmr_done;
    logic             sel_high;
    logic [CNT_W-1:0] limit;
    logic             bus_fell;

    scl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .bus_raw (scl_in),
        .view    (bus_v)
    );

    scl_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tmr_done  (tmr_done),
        .bus_rose  (bus_v.rose),
        .bus_fell  (bus_v.fell),
        .st_q      (st_q),
        .tmr_clear (tmr_clear),
        .tmr_run   (tmr_run),
        .sel_high  (sel_high)
    );

    assign limit = sel_high ? high_period : low_period;

    scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .run   (tmr_run),
        .limit (limit),
        .done  (tmr_done)
    );

    assign bus_fell      = bus_v.fell;
    assign scl_drive_low = (st_q == PH_LOW);
    assign wait_state    = en && phase_released(st_q) && !bus_v.level;
endmodule

// File: rtl/scl_clk_sync_chk.sv
module scl_clk_sync_chk
    import scl_sync_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   en,
    input logic   drv,
    input logic   wt,
    input phase_e st,
    input logic   bus_fell
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en)) |-> (!drv && !wt));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> drv);

    // R5
    wait_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PH_WAIT && en) |=> !drv);

    // R6
    fall_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PH_HIGH && en && bus_fell) |=> drv);

    // R7
    wait_excl_chk: assert property (@(posedge clk) disable iff (rst)
        wt |-> !drv);
endmodule

bind scl_clk_sync scl_clk_sync_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .drv      (scl_drive_low),
    .wt       (wait_state),
    .st       (st_q),
    .bus_fell (bus_fell)
);

// File: tb/scl_clk_sync_tb.sv
`timescale 1ns/100ps
module scl_clk_sync_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_a = 1'b0, en_b = 1'b0;
    logic [15:0] lo_a = 16'd10, hi_a = 16'd6, lo_b = 16'd10, hi_b = 16'd6;
    logic        ext_low = 1'b0;
    logic        drv_a, drv_b, wt_a, wt_b;
    logic        bus;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    assign bus = ~(drv_a | drv_b | ext_low);

    scl_clk_sync u_dut (
        .clk(clk), .rst(rst), .en(en_a), .low_period(lo_a), .high_period(hi_a),
        .scl_in(bus), .scl_drive_low(drv_a), .wait_state(wt_a));

    scl_clk_sync u_peer (
        .clk(clk), .rst(rst), .en(en_b), .low_period(lo_b), .high_period(hi_b),
        .scl_in(bus), .scl_drive_low(drv_b), .wait_state(wt_b));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input int la, input int ha, input logic ea,
                         input int lb, input int hb, input logic eb);
        @(negedge clk);
        en_a = 1'b0; en_b = 1'b0; ext_low = 1'b0;
        repeat (6) @(negedge clk);
        lo_a = 16'(la); hi_a = 16'(ha); lo_b = 16'(lb); hi_b = 16'(hb);
        en_a = ea; en_b = eb;
    endtask

    // one bus period: low run length then high run length, sampled at negedges
    task automatic measure(output int lo, output int hi);
        int g;
        lo = 0; hi = 0;
        g = 0; while (bus !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
        g = 0; while (bus !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
        while (bus === 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
        while (bus === 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset drive", drv_a, 0);
        chk("R1 reset wait", wt_a, 0);
    endtask

    task automatic t_enable;
        setup(12, 6, 1'b0, 10, 10, 1'b0);
        en_a = 1'b1;
        @(negedge clk);
        chk("R2 low after enable", drv_a, 1);
    endtask

    task automatic t_solo;
        int lo, hi, w;
        setup(12, 6, 1'b1, 10, 10, 1'b0);
        measure(lo, hi);
        measure(lo, hi);
        chk("R3 solo low", lo, 12);
        chk("R4 solo high", hi, 9);
        // count wait cycles from release to next drive
        while (drv_a !== 1'b1) @(negedge clk);
        while (drv_a === 1'b1) @(negedge clk);
        w = 0;
        while (drv_a !== 1'b1) begin if (wt_a) w++; @(negedge clk); end
        chk("R7 solo wait cycles", w, 2);
    endtask

    task automatic t_hold;
        int bad, hi;
        setup(10, 6, 1'b1, 10, 10, 1'b0);
        while (drv_a !== 1'b1) @(negedge clk);
        while (drv_a === 1'b1) @(negedge clk);
        ext_low = 1'b1;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (drv_a !== 1'b0 || wt_a !== 1'b1) bad++;
        end
        chk("R5 R7 held low: released and waiting", bad, 0);
        ext_low = 1'b0;
        hi = 0;
        @(negedge clk);
        while (bus === 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
        // release mid-cycle: samples after it = high_period + 2
        chk("R5 high after hold", hi, 8);
    endtask

    task automatic t_pulse;
        int lo;
        setup(10, 30, 1'b1, 10, 10, 1'b0);
        while (bus !== 1'b0) @(negedge clk);
        while (bus !== 1'b1) @(negedge clk);
        repeat (10) @(negedge clk);
        ext_low = 1'b1;
        @(negedge clk);
        ext_low = 1'b0;
        chk("R6 no drive one cycle after fall", drv_a, 0);
        @(negedge clk);
        chk("R6 no drive two cycles after fall", drv_a, 0);
        @(negedge clk);
        chk("R6 drive three cycles after fall", drv_a, 1);
        lo = 0;
        while (drv_a === 1'b1 && lo < 5000) begin lo++; @(negedge clk); end
        chk("R6 R3 full low after restart", lo, 10);
    endtask

    task automatic t_zero;
        int lo, hi;
        setup(0, 0, 1'b1, 10, 10, 1'b0);
        measure(lo, hi);
        measure(lo, hi);
        chk("R8 zero low", lo, 1);
        chk("R8 zero high", hi, 4);
    endtask

    task automatic t_pair(input int la, input int ha, input int lb, input int hb);
        int lo, hi, exp_hi, lead, foll, exp_lo;
        setup(la, ha, 1'b1, lb, hb, 1'b1);
        exp_hi = ((ha < hb) ? ha : hb) + 3;
        lead   = (ha < hb) ? la : lb;
        foll   = (ha < hb) ? lb : la;
        exp_lo = (lead > foll + 3) ? lead : foll + 3;
        measure(lo, hi);
        measure(lo, hi);
        measure(lo, hi);
        chk("R9 shared low", lo, exp_lo);
        chk("R9 shared high", hi, exp_hi);
    endtask

    task automatic t_disable;
        int bad;
        setup(20, 10, 1'b1, 10, 10, 1'b0);
        while (drv_a !== 1'b1) @(negedge clk);
        en_a = 1'b0;
        @(negedge clk);
        chk("R1 released after disable", drv_a, 0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (drv_a !== 1'b0 || wt_a !== 1'b0) bad++;
        end
        chk("R1 stays idle", bad, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_solo();
        t_hold();
        t_pulse();
        t_zero();
        t_pair(20, 8, 30, 15);
        t_pair(40, 5, 10, 20);
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule